// File: doc/BRIEF.md
# Low-Frequency Tag Write Frame Encoder

This block turns one write request into the timed on/off pattern that a reader's modulation switch needs to program a byte of a passive low-frequency tag. A single start strobe captures the password, the block and byte addresses, the data byte, a power-up delay and two signed trims. The block then runs through the whole frame by itself. Carrier generation and reception stay outside it.

The frame has four parts. A long high period powers and wakes the tag. It is followed by a short low notch and then a serial bit stream. Every bit takes 128 base units: a high stretch, a short low pulse, and a closing high stretch. A one and a zero differ only in where the low pulse falls. One trim widens or narrows the low pulse. The other shifts it earlier or later while the bit period stays fixed. After the last bit the output stays high so the tag can commit the write. It then drops to its idle low level, and a one-cycle completion pulse marks the end of the frame.

All times are given in microseconds. They become clock cycles through a cycles-per-microsecond parameter and a base unit T0 (8 µs by default).

Top module: `lf_write_encoder`

## Requirements
- R1: Out of reset, `mod_out`, `busy` and `done` are all low.
- R2: A frame opens with one high stretch of (init_us + 4096·T0) + (4415·T0 + 70 µs). A low of 3·T0 follows. Then comes a high of 29·T0, which runs straight into the first bit's leading high.
- R3: A bit of value 1 is high for 34·T0 + p, low for 6·T0 + w, then high for 88·T0 − w − p. Here w is the width trim and p is the position trim, both in µs.
- R4: A bit of value 0 is high for 98·T0 + p, low for 6·T0 + w, then high for 24·T0 − w − p.
- R5: Exactly 77 bits are sent, in this order, each field least significant bit first:
  - a constant 1
  - the 56-bit password, bits 0 to 55 (byte 0 first, so password bit 0 goes first)
  - a constant 0
  - the 6-bit block address
  - the 4-bit byte address
  - the 8-bit data
  - the check bit
- R6: The check bit is the XOR of all bits of the block address, the byte address and the data. The password does not enter it.
- R7: After the last bit the output stays high for a further 7800 µs. In the cycle after that hold ends, `mod_out` is low, `busy` is low and `done` is high, for that one cycle only.
- R8: A start pulse while `busy` is high is ignored. The frame in progress keeps its captured fields and timing, and no second frame follows.
- R9: Each trim is limited to ±2·T0 µs before use, so every segment keeps a positive length.
- R10: `busy` rises in the cycle after start is sampled and stays high until the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame when idle |
| pwd | input | 56 | Password, sent bit 0 first |
| blk_addr | input | 6 | Block address |
| byte_addr | input | 4 | Byte address within the block |
| wr_data | input | 8 | Byte to write |
| init_us | input | INIT_W | Extra power-up high time in µs |
| trim_w | input | TRIM_W | Signed low-pulse width trim in µs |
| trim_pos | input | TRIM_W | Signed low-pulse position trim in µs |
| mod_out | output | 1 | Modulation switch, idle low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a frame, carrying different fields and trims. The harm it could do shows up only as a changed pulse length many bits later, or as a second frame. The bench pulses start with fresh values well into the bit stream. It then checks every one of the 157 measured high and low run lengths against the model built from the first request, and watches that `busy` stays low after completion. Saturating trims are driven with out-of-range values, and each low run is compared against the clamped expectation.

// File: rtl/lf_write_encoder.sv
module lf_write_encoder #(
  parameter int CYC_PER_US    = 48,
  parameter int T0_US         = 8,
  parameter int PWR_T0        = 4096,
  parameter int WAKE_HI_T0    = 4415,
  parameter int WAKE_EXTRA_US = 70,
  parameter int WAKE_LO_T0    = 3,
  parameter int WAKE_TAIL_T0  = 29,
  parameter int HOLD_US       = 7800,
  parameter int INIT_W        = 16,
  parameter int TRIM_W        = 8,
  parameter int CNT_W         = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [55:0]              pwd,
  input  logic [5:0]               blk_addr,
  input  logic [3:0]               byte_addr,
  input  logic [7:0]               wr_data,
  input  logic [INIT_W-1:0]        init_us,
  input  logic signed [TRIM_W-1:0] trim_w,
  input  logic signed [TRIM_W-1:0] trim_pos,
  output logic                     mod_out,
  output logic                     busy,
  output logic                     done
);
  localparam int T0C      = T0_US * CYC_PER_US;
  localparam int TRIM_LIM = 2 * T0_US;
  localparam int NBITS    = 1 + 56 + 1 + 6 + 4 + 8 + 1;
  localparam int NB_W     = $clog2(NBITS + 1);

  typedef enum logic [3:0] {IDLE, PWR, WHI, WLO, WTAIL, BHI, BLO, BEND, HOLD} st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [NBITS-1:0] sh;
  logic [NB_W-1:0]  nleft;
  int               lw_q, pp_q, nlen;
  logic             nb;

  function automatic int clampt(input int v);
    if (v > TRIM_LIM) return TRIM_LIM;
    if (v < -TRIM_LIM) return -TRIM_LIM;
    return v;
  endfunction

  wire parity = ^{blk_addr, byte_addr, wr_data};

  assign busy    = (st != IDLE);
  assign mod_out = !(st == IDLE || st == WLO || st == BLO);
  assign nb      = (st == BEND) ? sh[1] : sh[0];

  always_comb begin
    case (st)
      IDLE:    nxt = PWR;
      PWR:     nxt = WHI;
      WHI:     nxt = WLO;
      WLO:     nxt = WTAIL;
      WTAIL:   nxt = BHI;
      BHI:     nxt = BLO;
      BLO:     nxt = BEND;
      BEND:    nxt = (nleft == NB_W'(1)) ? HOLD : BHI;
      default: nxt = IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      PWR:     nlen = (int'(init_us) + PWR_T0 * T0_US) * CYC_PER_US;
      WHI:     nlen = (WAKE_HI_T0 * T0_US + WAKE_EXTRA_US) * CYC_PER_US;
      WLO:     nlen = WAKE_LO_T0 * T0C;
      WTAIL:   nlen = WAKE_TAIL_T0 * T0C;
      BHI:     nlen = (nb ? 34 : 98) * T0C + pp_q * CYC_PER_US;
      BLO:     nlen = 6 * T0C + lw_q * CYC_PER_US;
      BEND:    nlen = (nb ? 88 : 24) * T0C - (lw_q + pp_q) * CYC_PER_US;
      HOLD:    nlen = HOLD_US * CYC_PER_US;
      default: nlen = 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      sh    <= '0;
      nleft <= '0;
      lw_q  <= 0;
      pp_q  <= 0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          st    <= PWR;
          cnt   <= CNT_W'(nlen - 1);
          sh    <= {parity, wr_data, byte_addr, blk_addr, 1'b0, pwd, 1'b1};
          nleft <= NB_W'(NBITS);
          lw_q  <= clampt(int'(trim_w));
          pp_q  <= clampt(int'(trim_pos));
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        st  <= nxt;
        cnt <= CNT_W'(nlen - 1);
        if (st == BEND) begin
          sh    <= sh >> 1;
          nleft <= nleft - 1'b1;
        end
        if (st == HOLD) done <= 1'b1;
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == HOLD) && !busy && !mod_out);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && st != PWR) |=> st != PWR);
  a_r9_trim_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lw_q <= TRIM_LIM && lw_q >= -TRIM_LIM && pp_q <= TRIM_LIM && pp_q >= -TRIM_LIM));
  a_r5_all_bits_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> (nleft == '0));
endmodule

// File: tb/sim_lf_write_encoder.sv
module sim_lf_write_encoder;
  localparam int CPU = 1, T0 = 2, PWRT = 32, WHT = 40, WEX = 5, HOLDU = 100;
  localparam int NRUNS = 157;

  logic clk = 0, rst_n = 0, start = 0;
  logic [55:0] pwd = '0;
  logic [5:0] blk_addr = '0;
  logic [3:0] byte_addr = '0;
  logic [7:0] wr_data = '0;
  logic [15:0] init_us = '0;
  logic signed [7:0] trim_w = '0, trim_pos = '0;
  logic mod_out, busy, done;

  int total = 0, bad = 0;
  int runs [0:199];
  int nruns = 0, run = 0;
  logic lvl = 0;
  int exp_r [0:NRUNS-1];
  string tag_r [0:NRUNS-1];

  always #10 clk = ~clk;

  lf_write_encoder #(.CYC_PER_US(CPU), .T0_US(T0), .PWR_T0(PWRT), .WAKE_HI_T0(WHT),
    .WAKE_EXTRA_US(WEX), .WAKE_LO_T0(3), .WAKE_TAIL_T0(29), .HOLD_US(HOLDU),
    .INIT_W(16), .TRIM_W(8), .CNT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pwd(pwd), .blk_addr(blk_addr),
    .byte_addr(byte_addr), .wr_data(wr_data), .init_us(init_us), .trim_w(trim_w),
    .trim_pos(trim_pos), .mod_out(mod_out), .busy(busy), .done(done));

  always @(negedge clk) begin
    if (mod_out == lvl) run++;
    else begin
      if ((lvl || nruns > 0) && nruns < 200) begin
        runs[nruns] = run;
        nruns++;
      end
      lvl = mod_out;
      run = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int expv, input string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int clampt(input int v);
    if (v > 2 * T0) return 2 * T0;
    if (v < -2 * T0) return -2 * T0;
    return v;
  endfunction

  task automatic build(input int iu, input logic [55:0] pw, input logic [5:0] ba,
                       input logic [3:0] by, input logic [7:0] d, input int tw, input int tp);
    logic [76:0] b;
    int lc, pc, lo;
    b = {^{ba, by, d}, d, by, ba, 1'b0, pw, 1'b1};
    lc = clampt(tw);
    pc = clampt(tp);
    lo = 6 * T0 * CPU + lc * CPU;
    exp_r[0] = (iu + PWRT * T0 + WHT * T0 + WEX) * CPU;
    exp_r[1] = 3 * T0 * CPU;
    exp_r[2] = 29 * T0 * CPU + (b[0] ? 34 : 98) * T0 * CPU + pc * CPU;
    tag_r[0] = "R2"; tag_r[1] = "R2"; tag_r[2] = "R2";
    for (int i = 0; i < 77; i++) begin
      int e;
      e = (b[i] ? 88 : 24) * T0 * CPU - (lc + pc) * CPU;
      exp_r[3 + 2 * i] = lo;
      tag_r[3 + 2 * i] = "R9";
      if (i < 76) begin
        exp_r[4 + 2 * i] = e + (b[i + 1] ? 34 : 98) * T0 * CPU + pc * CPU;
        tag_r[4 + 2 * i] = (i == 75) ? "R6" : (b[i] ? "R3" : "R4");
      end else begin
        exp_r[4 + 2 * i] = e + HOLDU * CPU;
        tag_r[4 + 2 * i] = "R7";
      end
    end
  endtask

  task automatic run_frame(input int iu, input logic [55:0] pw, input logic [5:0] ba,
                           input logic [3:0] by, input logic [7:0] d, input int tw,
                           input int tp, input bit poke);
    int waited, seqbad;
    build(iu, pw, ba, by, d, tw, tp);
    @(negedge clk);
    nruns = 0;
    init_us = 16'(iu); pwd = pw; blk_addr = ba; byte_addr = by; wr_data = d;
    trim_w = 8'(tw); trim_pos = 8'(tp);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R10", int'(busy), 1, "busy after start");
    if (poke) begin
      repeat (3000) @(negedge clk);
      pwd = ~pw; blk_addr = ~ba; byte_addr = ~by; wr_data = ~d;
      init_us = 16'd7; trim_w = -8'sd3; trim_pos = 8'sd2;
      start = 1;
      @(negedge clk);
      start = 0;
      chk("R8", int'(busy), 1, "busy during ignored start");
    end
    waited = 0;
    while (!done && waited < 40000) begin
      @(negedge clk);
      waited++;
      if (!done && !busy) begin
        chk("R10", int'(busy), 1, "busy before completion");
        waited = 40000;
      end
    end
    chk("R7", int'(done), 1, "done pulse seen");
    chk("R7", int'(mod_out), 0, "output low at done");
    chk("R10", int'(busy), 0, "busy low at done");
    @(negedge clk);
    chk("R7", int'(done), 0, "done lasts one cycle");
    #1;
    chk("R5", nruns, NRUNS, "run count");
    seqbad = 0;
    for (int k = 0; k < NRUNS; k++) begin
      total++;
      if (runs[k] != exp_r[k]) begin
        bad++;
        seqbad++;
        $display("FAIL %s run %0d: actual=%0d expected=%0d", tag_r[k], k, runs[k], exp_r[k]);
      end
    end
    chk("R5", seqbad, 0, "mismatching runs in frame");
    repeat (5) @(negedge clk);
    chk("R8", int'(busy), 0, "no second frame");
    chk("R7", int'(mod_out), 0, "idle low after frame");
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", int'(mod_out), 0, "mod_out in reset");
    chk("R1", int'(busy), 0, "busy in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", int'(mod_out), 0, "mod_out idle");
    chk("R1", int'(busy), 0, "busy idle");
    chk("R1", int'(done), 0, "done idle");
  endtask

  task automatic test_basic();
    run_frame(10, 56'h81_7E_42_A5_3C_00_FF, 6'h2A, 4'h5, 8'hC3, 0, 0, 0);
  endtask

  task automatic test_all_ones_trim();
    run_frame(0, 56'h0, 6'h3F, 4'hF, 8'hFF, 3, -2, 0);
  endtask

  task automatic test_clamp();
    run_frame(3, 56'hFF_FF_FF_FF_FF_FF_FF, 6'h01, 4'h0, 8'h00, 100, -128, 0);
  endtask

  task automatic test_ignore_start();
    run_frame(500, 56'h12_34_56_78_9A_BC_DE, 6'h15, 4'hA, 8'h5A, -4, 4, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_all_ones_trim();
    test_clamp();
    test_ignore_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule